// File: doc/BRIEF.md
# Bridge Miscellaneous Control Registers

This block holds two 8-bit read/write control registers for a PCI-to-ISA bridge, plus a small command register. From their contents it derives the control outputs that the bridge's transaction engine and reset generator consume. Software writes bytes through a plain port with an offset, a write enable and write data. It reads any register back through a combinational read-data port.

Several outputs depend on more than one bit, or on how a register reacts to a write. The effective posted memory write enable is on when either its own bit or the delay-transaction bit of the other register is set. One bit does not store: writing a 1 there fires a one-cycle PCI reset request. One reserved bit is always stored as 0. A test-mode bit swaps which command-register bits accept writes.

Top module: `brg_misc_ctl`

## Requirements
- R1: After reset, the registers at offsets 0x50, 0x51 and 0x04 read 0x00, and every control output is 0.
- R2: `post_wr_eff` equals bit 0 of offset 0x50 OR bit 6 of offset 0x51, updated on the clock edge that takes the write.
- R3: A write to offset 0x51 with bit 0 set raises `pci_rst_req` for exactly the one cycle after the write edge; bit 0 of 0x51 always reads 0.
- R4: Bit 3 of offset 0x51 is stored as 0 and reads 0 whatever value is written to it.
- R5: With bit 4 of 0x50 clear (normal mode), a write to 0x04 updates bit 3 and leaves bits 1:0 unchanged.
- R6: With bit 4 of 0x50 set (test mode), a write to 0x04 updates bits 1:0 and leaves bit 3 unchanged; bits 7:4 and 2 of 0x04 always read 0.
- R7: `mst_wr_ws` follows bit 7 of 0x50, `burst_rd_hold` follows bit 1 of 0x50, and `cpu_rst_init` follows bit 7 of 0x51.
- R8: `wr_to_en` follows bit 2 of 0x51 and `rd_to_en` follows bit 1 of 0x51, each independently of the other.
- R9: Writes to any other offset change no register and no output, and reads from any other offset return 0x00.
- R10: Every bit of 0x50 and bits 7:4 and 2:1 of 0x51 read back as last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ofs | input | 8 | Register byte offset |
| wr_en | input | 1 | Write strobe, one byte per cycle |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Combinational read data for `ofs` |
| post_wr_eff | output | 1 | Effective posted memory write enable |
| burst_rd_hold | output | 1 | 1 = PCI burst reads may not be interrupted |
| mst_wr_ws | output | 1 | 1 = one wait state on PCI master writes |
| wr_to_en | output | 1 | Write delay-transaction timeout timer enable |
| rd_to_en | output | 1 | Read delay-transaction timeout timer enable |
| cpu_rst_init | output | 1 | 1 = use INIT as CPU reset, 0 = use reset pin |
| pci_rst_req | output | 1 | One-cycle PCI bus reset request |

## Verification
A corrupted stored bit shows at once, in the next readback of its offset and on the output it drives. The readback is combinational, so the error appears in the same cycle the offset is presented. A wrong access mask on the command register stays hidden until a later write tries to change a protected bit. It can only be exposed by toggling the test mode between writes and reading back. A broken reset strobe shows either as a pulse that is missing or lasts too long on the cycle after the write, or as bit 0 of 0x51 reading back as 1.

// File: rtl/brg_misc_pkg.sv
package brg_misc_pkg;
  localparam int unsigned REG_W = 8;

  // first control register bit positions
  localparam int unsigned A_POST   = 0;
  localparam int unsigned A_BURST  = 1;
  localparam int unsigned A_TEST   = 4;
  localparam int unsigned A_WS     = 7;
  // second control register bit positions
  localparam int unsigned B_PRST   = 0;
  localparam int unsigned B_RDTO   = 1;
  localparam int unsigned B_WRTO   = 2;
  localparam int unsigned B_RSVD   = 3;
  localparam int unsigned B_DLY    = 6;
  localparam int unsigned B_CPURST = 7;

  // bits of the second register that never hold state
  localparam logic [REG_W-1:0] B_ZERO_MASK = (REG_W'(1) << B_PRST) | (REG_W'(1) << B_RSVD);
  // command register access masks
  localparam logic [REG_W-1:0] CMD_NRM_MASK = 8'h08;
  localparam logic [REG_W-1:0] CMD_TST_MASK = 8'h03;

  typedef struct packed {
    logic a;
    logic b;
    logic cmd;
  } hit_t;

  function automatic logic post_eff(input logic [REG_W-1:0] a, input logic [REG_W-1:0] b);
    return a[A_POST] | b[B_DLY];
  endfunction

  function automatic logic [REG_W-1:0] cmd_wmask(input logic test);
    return test ? CMD_TST_MASK : CMD_NRM_MASK;
  endfunction

  function automatic logic [REG_W-1:0] merge(input logic [REG_W-1:0] old_v,
                                              input logic [REG_W-1:0] new_v,
                                              input logic [REG_W-1:0] mask);
    return (old_v & ~mask) | (new_v & mask);
  endfunction
endpackage

// File: rtl/brg_addr_dec.sv
module brg_addr_dec
  import brg_misc_pkg::*;
#(
  parameter int unsigned OFS_W = 8,
  parameter logic [OFS_W-1:0] OFS_A = 8'h50,
  parameter logic [OFS_W-1:0] OFS_B = 8'h51,
  parameter logic [OFS_W-1:0] OFS_C = 8'h04
) (
  input  logic [OFS_W-1:0] ofs,
  output hit_t             hit
);
  always_comb begin
    hit.a   = (ofs == OFS_A);
    hit.b   = (ofs == OFS_B);
    hit.cmd = (ofs == OFS_C);
  end
endmodule

// File: rtl/brg_cfg_reg.sv
module brg_cfg_reg #(
  parameter int unsigned W = 8,
  parameter logic [W-1:0] ZERO_MASK = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] wd,
  output logic [W-1:0] q
);
  logic unused_zero_bits;
  assign unused_zero_bits = ^(wd & ZERO_MASK);

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (ZERO_MASK[i]) begin : g_zero
      assign q[i] = 1'b0;
    end else begin : g_flop
      logic bit_q;
      always_ff @(posedge clk) begin
        if (!rst_n)  bit_q <= 1'b0;
        else if (we) bit_q <= wd[i];
      end
      assign q[i] = bit_q;
    end
  end
endmodule

// File: rtl/brg_cmd_reg.sv
module brg_cmd_reg
  import brg_misc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic             test,
  input  logic [REG_W-1:0] wd,
  output logic [REG_W-1:0] q
);
  localparam logic [REG_W-1:0] IMPL = CMD_NRM_MASK | CMD_TST_MASK;

  logic [REG_W-1:0] wmask;
  logic [REG_W-1:0] nxt;
  logic             unused_cmd_bits;

  assign wmask = we ? cmd_wmask(test) : '0;
  assign nxt   = merge(q, wd, wmask);
  assign unused_cmd_bits = ^(wd & ~IMPL) ^ ^(nxt & ~IMPL);

  for (genvar i = 0; i < REG_W; i++) begin : g_bit
    if (!IMPL[i]) begin : g_none
      assign q[i] = 1'b0;
    end else begin : g_flop
      logic bit_q;
      always_ff @(posedge clk) begin
        if (!rst_n) bit_q <= 1'b0;
        else        bit_q <= nxt[i];
      end
      assign q[i] = bit_q;
    end
  end
endmodule

// File: rtl/brg_pulse.sv
module brg_pulse (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic q
);
  always_ff @(posedge clk) begin
    if (!rst_n) q <= 1'b0;
    else        q <= fire;
  end
endmodule

// File: rtl/brg_misc_ctl.sv
module brg_misc_ctl
  import brg_misc_pkg::*;
#(
  parameter int unsigned OFS_W = 8,
  parameter logic [OFS_W-1:0] OFS_A = 8'h50,
  parameter logic [OFS_W-1:0] OFS_B = 8'h51,
  parameter logic [OFS_W-1:0] OFS_C = 8'h04
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OFS_W-1:0] ofs,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] rdata,
  output logic             post_wr_eff,
  output logic             burst_rd_hold,
  output logic             mst_wr_ws,
  output logic             wr_to_en,
  output logic             rd_to_en,
  output logic             cpu_rst_init,
  output logic             pci_rst_req
);
  hit_t             hit;
  logic             wr_a, wr_b, wr_cmd;
  logic             cmd_test;
  logic             rst_fire;
  logic [REG_W-1:0] ctl_a_q, ctl_b_q, cmd_q;

  brg_addr_dec #(.OFS_W(OFS_W), .OFS_A(OFS_A), .OFS_B(OFS_B), .OFS_C(OFS_C)) u_dec (
    .ofs (ofs),
    .hit (hit)
  );

  assign wr_a     = wr_en & hit.a;
  assign wr_b     = wr_en & hit.b;
  assign wr_cmd   = wr_en & hit.cmd;
  assign rst_fire = wr_b & wdata[B_PRST];

  brg_cfg_reg #(.W(REG_W), .ZERO_MASK('0)) u_ctl_a (
    .clk (clk), .rst_n (rst_n), .we (wr_a), .wd (wdata), .q (ctl_a_q)
  );

  brg_cfg_reg #(.W(REG_W), .ZERO_MASK(B_ZERO_MASK)) u_ctl_b (
    .clk (clk), .rst_n (rst_n), .we (wr_b), .wd (wdata), .q (ctl_b_q)
  );

  assign cmd_test = ctl_a_q[A_TEST];

  brg_cmd_reg u_cmd (
    .clk (clk), .rst_n (rst_n), .we (wr_cmd), .test (cmd_test), .wd (wdata), .q (cmd_q)
  );

  brg_pulse u_prst (
    .clk (clk), .rst_n (rst_n), .fire (rst_fire), .q (pci_rst_req)
  );

  always_comb begin
    rdata = '0;
    if (hit.a)   rdata = ctl_a_q;
    if (hit.b)   rdata = ctl_b_q;
    if (hit.cmd) rdata = cmd_q;
  end

  assign post_wr_eff   = post_eff(ctl_a_q, ctl_b_q);
  assign burst_rd_hold = ctl_a_q[A_BURST];
  assign mst_wr_ws     = ctl_a_q[A_WS];
  assign wr_to_en      = ctl_b_q[B_WRTO];
  assign rd_to_en      = ctl_b_q[B_RDTO];
  assign cpu_rst_init  = ctl_b_q[B_CPURST];
endmodule

// File: rtl/brg_misc_ctl_chk.sv
module brg_misc_ctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_a,
  input logic       wr_b,
  input logic       wr_cmd,
  input logic       any_hit,
  input logic       cmd_test,
  input logic [7:0] wdata,
  input logic [7:0] rdata,
  input logic [7:0] ctl_b_q,
  input logic [7:0] cmd_q,
  input logic [4:0] plain_outs,
  input logic       post_wr_eff,
  input logic       pci_rst_req
);
  AST_PULSE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    pci_rst_req |-> $past(wr_b && wdata[0])); // R3

  AST_RSVD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_b_q[3] && !ctl_b_q[0]); // R4

  AST_POST_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(post_wr_eff) |-> $past(wr_a || wr_b)); // R2

  AST_CMD_LO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_cmd && cmd_test) |=> $stable(cmd_q[1:0])); // R6

  AST_CMD_B3_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_cmd && !cmd_test) |=> $stable(cmd_q[3])); // R5

  AST_MISS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !any_hit |-> rdata == 8'h00); // R9

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_a || wr_b) |=> $stable(plain_outs)); // R9
endmodule

bind brg_misc_ctl brg_misc_ctl_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_a        (wr_a),
  .wr_b        (wr_b),
  .wr_cmd      (wr_cmd),
  .any_hit     (hit.a | hit.b | hit.cmd),
  .cmd_test    (cmd_test),
  .wdata       (wdata),
  .rdata       (rdata),
  .ctl_b_q     (ctl_b_q),
  .cmd_q       (cmd_q),
  .plain_outs  ({burst_rd_hold, mst_wr_ws, wr_to_en, rd_to_en, cpu_rst_init}),
  .post_wr_eff (post_wr_eff),
  .pci_rst_req (pci_rst_req)
);

// File: tb/brg_misc_ctl_tb.sv
module brg_misc_ctl_tb;
  localparam logic [7:0] A = 8'h50, B = 8'h51, C = 8'h04;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] ofs = '0;
  logic       wr_en = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic post_wr_eff, burst_rd_hold, mst_wr_ws, wr_to_en, rd_to_en, cpu_rst_init, pci_rst_req;

  always #4 clk = ~clk;

  brg_misc_ctl u_dut (
    .clk (clk), .rst_n (rst_n), .ofs (ofs), .wr_en (wr_en), .wdata (wdata),
    .rdata (rdata), .post_wr_eff (post_wr_eff), .burst_rd_hold (burst_rd_hold),
    .mst_wr_ws (mst_wr_ws), .wr_to_en (wr_to_en), .rd_to_en (rd_to_en),
    .cpu_rst_init (cpu_rst_init), .pci_rst_req (pci_rst_req)
  );

  typedef struct {
    bit         is_rd;
    logic [7:0] exp;
    string      tag;
  } item_t;

  item_t q[$];
  int    checks = 0;
  int    errors = 0;
  bit    done = 0;
  event  chk_ev;

  // output vector: {post, burst, ws, wrto, rdto, cpu, prst}
  function automatic logic [7:0] outs();
    return {1'b0, post_wr_eff, burst_rd_hold, mst_wr_ws, wr_to_en, rd_to_en, cpu_rst_init, pci_rst_req};
  endfunction

  // monitor
  initial begin
    forever begin
      @(chk_ev);
      while (q.size() > 0) begin
        item_t it;
        logic [7:0] act;
        it  = q.pop_front();
        act = it.is_rd ? rdata : outs();
        checks++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s: actual 0x%02h expected 0x%02h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic wr(input logic [7:0] o, input logic [7:0] d);
    @(negedge clk);
    ofs = o; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic exp_rd(input logic [7:0] o, input logic [7:0] e, input string tag);
    ofs = o;
    #1;
    q.push_back('{1'b1, e, tag});
    -> chk_ev;
    wait (q.size() == 0);
  endtask

  task automatic exp_out(input logic [6:0] e, input string tag);
    #1;
    q.push_back('{1'b0, {1'b0, e}, tag});
    -> chk_ev;
    wait (q.size() == 0);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    exp_rd(A, 8'h00, "R1 reg A");
    exp_rd(B, 8'h00, "R1 reg B");
    exp_rd(C, 8'h00, "R1 cmd");
    exp_out(7'b0000000, "R1 outputs");

    // R2 effective posted write
    wr(A, 8'h01);  exp_out(7'b1000000, "R2 own bit");
    wr(A, 8'h00);  exp_out(7'b0000000, "R2 own bit clear");
    wr(B, 8'h40);  exp_out(7'b1000000, "R2 delay bit forces");
    exp_rd(A, 8'h00, "R2 own bit untouched");
    wr(A, 8'h01);  wr(B, 8'h00); exp_out(7'b1000000, "R2 own bit alone");
    wr(A, 8'h00);  exp_out(7'b0000000, "R2 both clear");

    // R3 reset strobe
    wr(B, 8'h01);  exp_out(7'b0000001, "R3 pulse after write");
    exp_rd(B, 8'h00, "R3 bit0 reads 0");
    @(negedge clk); exp_out(7'b0000000, "R3 pulse one cycle");

    // R4 reserved bit
    wr(B, 8'h08);  exp_rd(B, 8'h00, "R4 reserved masked");
    wr(B, 8'hFF);  exp_out(7'b1001111, "R8 R7 R3 all B bits");
    exp_rd(B, 8'hF6, "R4 R10 B readback");
    @(negedge clk); exp_out(7'b1001110, "R3 pulse gone");

    // R8 independent timeouts
    wr(B, 8'h04);  exp_out(7'b0001000, "R8 write timeout only");
    wr(B, 8'h02);  exp_out(7'b0000100, "R8 read timeout only");
    // R7
    wr(B, 8'h80);  exp_out(7'b0000010, "R7 cpu reset source");
    wr(A, 8'h82);  exp_out(7'b0110010, "R7 ws and burst");
    exp_rd(A, 8'h82, "R10 A readback");

    // R5 / R6 command access swap
    wr(A, 8'h00);
    wr(C, 8'hFF);  exp_rd(C, 8'h08, "R5 normal write");
    wr(A, 8'h10);
    wr(C, 8'h03);  exp_rd(C, 8'h0B, "R6 test write lo");
    wr(C, 8'hF4);  exp_rd(C, 8'h08, "R6 test bit3 held");
    wr(C, 8'h03);  exp_rd(C, 8'h0B, "R6 test set again");
    wr(A, 8'h00);
    wr(C, 8'h00);  exp_rd(C, 8'h03, "R5 normal lo held");
    wr(B, 8'h80);

    // R9 unmapped offsets
    wr(8'h30, 8'hFF); exp_rd(8'h30, 8'h00, "R9 unmapped read");
    wr(8'h52, 8'hFF); exp_rd(8'h52, 8'h00, "R9 neighbour read");
    exp_rd(A, 8'h00, "R9 A unchanged");
    exp_rd(B, 8'h80, "R9 B unchanged");
    exp_rd(C, 8'h03, "R9 cmd unchanged");
    exp_out(7'b0000010, "R9 outputs unchanged");

    // R10 readback
    wr(A, 8'h6C);  exp_rd(A, 8'h6C, "R10 A pattern");
    wr(B, 8'h30);  exp_rd(B, 8'h30, "R10 B pattern");

    // R1 reset again
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    exp_rd(A, 8'h00, "R1 A after reset");
    exp_rd(C, 8'h00, "R1 cmd after reset");

    done = 1;
    finish_run();
  end
endmodule